// File: doc/BRIEF.md
# Polled Printer and Keyboard Port Block

This block sits on a CPU's memory bus and gives software two polled peripheral channels: a byte-wide output toward a printer and a byte-wide input from a keyboard. The CPU reaches each channel through fixed addresses in the normal memory space. It uses a 16-bit address, separate read and write strobes and a 16-bit data bus. Software polls a status word before it moves a byte. It reads the printer-ready flag before it writes a character, and it reads the key-available flag before it fetches a key code.

The printer side has a byte latch that drives the printer data pins and can be read back, plus a small handshake. The state machine has three states: `PRN_IDLE_READY`, `PRN_FIRE` and `PRN_AWAIT_ACK`. A data write in `PRN_IDLE_READY` moves to `PRN_FIRE`, which drives the one-cycle data strobe. `PRN_FIRE` always moves on to `PRN_AWAIT_ACK`. `PRN_AWAIT_ACK` returns to `PRN_IDLE_READY` when the acknowledge input is high. The keyboard side has two states, `KBD_EMPTY` and `KBD_HELD`. A key strobe enters `KBD_HELD` or stays there. A CPU read of the key code with no strobe in the same cycle returns to `KBD_EMPTY`. A strobe that arrives while a key is held and not being read sets a sticky overrun flag, which a read of the keyboard status word clears.

Read data is combinational. It is valid in the same cycle as the read strobe. All side effects of reads and writes take place at the clock edge that ends that cycle.

Top module: `pio_port_block`

## Requirements
- R1: After reset the printer data pins are 0x00, the data strobe is low, the printer-ready flag is 1, and the key-available and overrun flags are 0.
- R2: A write to 0xFFE0 stores bus_wdata[7:0] on the printer data pins at the next edge. This happens in every printer state. No read, no other address and no idle cycle changes the pins.
- R3: A read of 0xFFE0 returns the stored byte in bits 7:0, with bits 15:8 zero.
- R4: A read of 0xFFE2 returns the printer-ready flag in bit 0, with bits 15:1 zero. The flag is 1 only in `PRN_IDLE_READY`.
- R5: A write to 0xFFE0 in `PRN_IDLE_READY` raises prn_stb for exactly the one cycle after the write, and ready reads 0 in that cycle. A write in any other state produces no strobe.
- R6: Ready returns one cycle after prn_ack is sampled high in `PRN_AWAIT_ACK`. An ack in any other state has no effect.
- R7: kbd_stb stores kbd_data at the edge. From the next cycle, 0xFFE6 bit 0 reads 1, and 0xFFE4 returns the byte in bits 7:0 with bits 15:8 zero.
- R8: A read of 0xFFE4 clears the key-available flag at its edge unless kbd_stb is high in the same cycle. In that case the new byte is stored and the flag stays 1.
- R9: A strobe while a key is held and 0xFFE4 is not being read sets 0xFFE6 bit 1 (overrun) and replaces the byte. A read of 0xFFE6 clears overrun unless a new overrun occurs in the same cycle. Bits 15:2 of 0xFFE6 read 0.
- R10: Writes to 0xFFE2, 0xFFE4 and 0xFFE6 change no readable value and no output.
- R11: bus_rdata is 0 whenever bus_rd is low or the address is not one of the four ports.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 16 | CPU address |
| bus_rd | input | 1 | Read strobe |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data, combinational |
| prn_data | output | 8 | Printer data pins |
| prn_stb | output | 1 | One-cycle data-valid pulse to the printer |
| prn_ack | input | 1 | Printer acknowledge |
| kbd_data | input | 8 | Keyboard key code |
| kbd_stb | input | 1 | Keyboard byte-valid strobe |

## Verification
Read data is due in the same cycle as the read strobe, so the bench checks bus_rdata one time step after it drives the inputs. It checks the next-edge effects, meaning the printer pins, prn_stb, ready and the keyboard flags, in the cycle that follows the triggering edge. A behavioural model in the bench updates only at the edge. Every cycle, the bench compares the model's view against the read data, the printer pins and the strobe, so a pulse that arrives one cycle early, one cycle late or lasts too long shows up in the cycle where it differs. The stimulus covers ack in the wrong state, a strobe during a key-code read, and a new overrun during a status read.

// File: rtl/pio_pkg.sv
package pio_pkg;

    typedef enum logic [1:0] {
        PRN_IDLE_READY = 2'd0,
        PRN_FIRE       = 2'd1,
        PRN_AWAIT_ACK  = 2'd2
    } prn_state_t;

    typedef enum logic {
        KBD_EMPTY = 1'b0,
        KBD_HELD  = 1'b1
    } kbd_state_t;

    typedef enum logic [2:0] {
        SEL_NONE     = 3'd0,
        SEL_PRN_DATA = 3'd1,
        SEL_PRN_STAT = 3'd2,
        SEL_KBD_DATA = 3'd3,
        SEL_KBD_STAT = 3'd4
    } rd_sel_t;

    typedef struct packed {
        logic prn_data_wr;
        logic prn_data_rd;
        logic prn_stat_rd;
        logic kbd_data_rd;
        logic kbd_stat_rd;
    } hits_t;

endpackage

// File: rtl/pio_bus_decode.sv
module pio_bus_decode
    import pio_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 16,
    parameter int CHAR_W = 8,
    parameter logic [ADDR_W-1:0] PRN_DATA_ADDR = 16'hFFE0,
    parameter logic [ADDR_W-1:0] PRN_STAT_ADDR = 16'hFFE2,
    parameter logic [ADDR_W-1:0] KBD_DATA_ADDR = 16'hFFE4,
    parameter logic [ADDR_W-1:0] KBD_STAT_ADDR = 16'hFFE6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_rd,
    input  logic              bus_wr,
    input  logic [CHAR_W-1:0] prn_byte,
    input  logic              prn_ready,
    input  logic [CHAR_W-1:0] kbd_byte,
    input  logic              key_avail,
    input  logic              overrun,
    output hits_t             hits,
    output logic [DATA_W-1:0] bus_rdata
);

    localparam int CHAR_PAD = DATA_W - CHAR_W;

    rd_sel_t sel;

    always_comb begin
        sel = SEL_NONE;
        if (bus_rd) begin
            if (bus_addr == PRN_DATA_ADDR)      sel = SEL_PRN_DATA;
            else if (bus_addr == PRN_STAT_ADDR) sel = SEL_PRN_STAT;
            else if (bus_addr == KBD_DATA_ADDR) sel = SEL_KBD_DATA;
            else if (bus_addr == KBD_STAT_ADDR) sel = SEL_KBD_STAT;
        end
    end

    always_comb begin
        hits             = '0;
        hits.prn_data_wr = bus_wr && (bus_addr == PRN_DATA_ADDR);
        hits.prn_data_rd = (sel == SEL_PRN_DATA);
        hits.prn_stat_rd = (sel == SEL_PRN_STAT);
        hits.kbd_data_rd = (sel == SEL_KBD_DATA);
        hits.kbd_stat_rd = (sel == SEL_KBD_STAT);
    end

    always_comb begin
        bus_rdata = '0;
        unique case (sel)
            SEL_NONE:     bus_rdata = '0;
            SEL_PRN_DATA: bus_rdata = {{CHAR_PAD{1'b0}}, prn_byte};
            SEL_PRN_STAT: bus_rdata = {{(DATA_W-1){1'b0}}, prn_ready};
            SEL_KBD_DATA: bus_rdata = {{CHAR_PAD{1'b0}}, kbd_byte};
            SEL_KBD_STAT: bus_rdata = {{(DATA_W-2){1'b0}}, overrun, key_avail};
            default:      bus_rdata = '0;
        endcase
    end

    // R11
    idle_rdata_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_rd |-> bus_rdata == '0);

endmodule

// File: rtl/pio_prn_chan.sv
module pio_prn_chan
    import pio_pkg::*;
#(
    parameter int CHAR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              data_wr,
    input  logic [CHAR_W-1:0] wr_byte,
    input  logic              prn_ack,
    output logic [CHAR_W-1:0] prn_data,
    output logic              prn_stb,
    output logic              prn_ready
);

    prn_state_t state, state_nx;

    always_ff @(posedge clk) begin
        if (!rst_n) state <= PRN_IDLE_READY;
        else        state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            PRN_IDLE_READY: if (data_wr) state_nx = PRN_FIRE;
            PRN_FIRE:       state_nx = PRN_AWAIT_ACK;
            PRN_AWAIT_ACK:  if (prn_ack) state_nx = PRN_IDLE_READY;
            default:        state_nx = PRN_IDLE_READY;
        endcase
    end

    always_comb begin
        prn_stb   = 1'b0;
        prn_ready = 1'b0;
        unique case (state)
            PRN_IDLE_READY: prn_ready = 1'b1;
            PRN_FIRE:       prn_stb   = 1'b1;
            PRN_AWAIT_ACK:  prn_ready = 1'b0;
            default:        prn_ready = 1'b0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n)       prn_data <= '0;
        else if (data_wr) prn_data <= wr_byte;
    end

    // R5
    stb_single_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        prn_stb |=> !prn_stb);
    // R5
    stb_after_ready_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (prn_ready && data_wr) |=> prn_stb);
    // R2
    latch_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !data_wr |=> $stable(prn_data));
    // R6
    ready_return_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == PRN_AWAIT_ACK && prn_ack) |=> prn_ready);

endmodule

// File: rtl/pio_kbd_chan.sv
module pio_kbd_chan
    import pio_pkg::*;
#(
    parameter int CHAR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              kbd_stb,
    input  logic [CHAR_W-1:0] kbd_data,
    input  logic              data_rd,
    input  logic              stat_rd,
    output logic [CHAR_W-1:0] kbd_byte,
    output logic              key_avail,
    output logic              overrun
);

    kbd_state_t state, state_nx;
    logic       lost_key;

    always_ff @(posedge clk) begin
        if (!rst_n) state <= KBD_EMPTY;
        else        state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        lost_key = 1'b0;
        unique case (state)
            KBD_EMPTY: if (kbd_stb) state_nx = KBD_HELD;
            KBD_HELD: begin
                if (kbd_stb) begin
                    state_nx = KBD_HELD;
                    lost_key = !data_rd;
                end else if (data_rd) begin
                    state_nx = KBD_EMPTY;
                end
            end
            default: state_nx = KBD_EMPTY;
        endcase
    end

    always_comb begin
        key_avail = 1'b0;
        unique case (state)
            KBD_EMPTY: key_avail = 1'b0;
            KBD_HELD:  key_avail = 1'b1;
            default:   key_avail = 1'b0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n)       kbd_byte <= '0;
        else if (kbd_stb) kbd_byte <= kbd_data;
    end

    always_ff @(posedge clk) begin
        if (!rst_n)        overrun <= 1'b0;
        else if (lost_key) overrun <= 1'b1;
        else if (stat_rd)  overrun <= 1'b0;
    end

    // R7
    key_flag_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        kbd_stb |=> key_avail);
    // R8
    key_flag_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (data_rd && !kbd_stb) |=> !key_avail);
    // R9
    overrun_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (kbd_stb && key_avail && !data_rd) |=> overrun);
    // R9
    overrun_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_rd && !kbd_stb) |=> !overrun);

endmodule

// File: rtl/pio_port_block.sv
module pio_port_block
    import pio_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 16,
    parameter int CHAR_W = 8,
    parameter logic [ADDR_W-1:0] PRN_DATA_ADDR = 16'hFFE0,
    parameter logic [ADDR_W-1:0] PRN_STAT_ADDR = 16'hFFE2,
    parameter logic [ADDR_W-1:0] KBD_DATA_ADDR = 16'hFFE4,
    parameter logic [ADDR_W-1:0] KBD_STAT_ADDR = 16'hFFE6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_rd,
    input  logic              bus_wr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic [CHAR_W-1:0] prn_data,
    output logic              prn_stb,
    input  logic              prn_ack,
    input  logic [CHAR_W-1:0] kbd_data,
    input  logic              kbd_stb
);

    hits_t             hits;
    logic              prn_ready;
    logic [CHAR_W-1:0] kbd_byte;
    logic              key_avail;
    logic              overrun;
    logic              unused_wdata_hi;

    assign unused_wdata_hi = ^bus_wdata[DATA_W-1:CHAR_W];

    pio_bus_decode #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CHAR_W(CHAR_W),
        .PRN_DATA_ADDR(PRN_DATA_ADDR), .PRN_STAT_ADDR(PRN_STAT_ADDR),
        .KBD_DATA_ADDR(KBD_DATA_ADDR), .KBD_STAT_ADDR(KBD_STAT_ADDR)
    ) u_decode (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_addr  (bus_addr),
        .bus_rd    (bus_rd),
        .bus_wr    (bus_wr),
        .prn_byte  (prn_data),
        .prn_ready (prn_ready),
        .kbd_byte  (kbd_byte),
        .key_avail (key_avail),
        .overrun   (overrun),
        .hits      (hits),
        .bus_rdata (bus_rdata)
    );

    pio_prn_chan #(.CHAR_W(CHAR_W)) u_prn (
        .clk       (clk),
        .rst_n     (rst_n),
        .data_wr   (hits.prn_data_wr),
        .wr_byte   (bus_wdata[CHAR_W-1:0]),
        .prn_ack   (prn_ack),
        .prn_data  (prn_data),
        .prn_stb   (prn_stb),
        .prn_ready (prn_ready)
    );

    pio_kbd_chan #(.CHAR_W(CHAR_W)) u_kbd (
        .clk       (clk),
        .rst_n     (rst_n),
        .kbd_stb   (kbd_stb),
        .kbd_data  (kbd_data),
        .data_rd   (hits.kbd_data_rd),
        .stat_rd   (hits.kbd_stat_rd),
        .kbd_byte  (kbd_byte),
        .key_avail (key_avail),
        .overrun   (overrun)
    );

endmodule

// File: tb/pio_port_block_tb.sv
module pio_port_block_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] bus_addr = '0;
    logic        bus_rd = 1'b0;
    logic        bus_wr = 1'b0;
    logic [15:0] bus_wdata = '0;
    logic [15:0] bus_rdata;
    logic [7:0]  prn_data;
    logic        prn_stb;
    logic        prn_ack = 1'b0;
    logic [7:0]  kbd_data = '0;
    logic        kbd_stb = 1'b0;

    int checks = 0;
    int errors = 0;

    // behavioural reference state
    int       m_pst = 0;   // 0 ready, 1 strobing, 2 waiting for ack
    bit [7:0] m_prn = 0;
    bit [7:0] m_kbd = 0;
    bit       m_full = 0;
    bit       m_ovr = 0;

    always #5 clk = ~clk;

    pio_port_block u_dut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_rd(bus_rd),
        .bus_wr(bus_wr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .prn_data(prn_data), .prn_stb(prn_stb), .prn_ack(prn_ack),
        .kbd_data(kbd_data), .kbd_stb(kbd_stb)
    );

    task automatic check(input string what, input string tag,
                         input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    function automatic logic [15:0] exp_rdata();
        if (!bus_rd) return 16'h0;
        case (bus_addr)
            16'hFFE0: return {8'h00, m_prn};
            16'hFFE2: return {15'h0, m_pst == 0};
            16'hFFE4: return {8'h00, m_kbd};
            16'hFFE6: return {14'h0, m_ovr, m_full};
            default:  return 16'h0;
        endcase
    endfunction

    // one bus cycle: drive, check combinational and registered outputs, take edge, update model
    task automatic step(input logic [15:0] a, input bit rd, input bit wr,
                        input logic [15:0] wd, input bit ack, input bit ks,
                        input logic [7:0] kd, input string tag);
        bit rd_kd, rd_ks, wr_pd;
        bus_addr = a; bus_rd = rd; bus_wr = wr; bus_wdata = wd;
        prn_ack = ack; kbd_stb = ks; kbd_data = kd;
        #1;
        check("rdata", tag, bus_rdata, exp_rdata());
        check("prn_data", tag, {8'h0, prn_data}, {8'h0, m_prn});
        check("prn_stb", tag, {15'h0, prn_stb}, {15'h0, m_pst == 1});
        @(posedge clk);
        rd_kd = rd && a == 16'hFFE4;
        rd_ks = rd && a == 16'hFFE6;
        wr_pd = wr && a == 16'hFFE0;
        if (wr_pd) m_prn = wd[7:0];
        case (m_pst)
            0: if (wr_pd) m_pst = 1;
            1: m_pst = 2;
            default: if (ack) m_pst = 0;
        endcase
        if (ks && m_full && !rd_kd) m_ovr = 1;
        else if (rd_ks) m_ovr = 0;
        if (ks) begin m_full = 1; m_kbd = kd; end
        else if (rd_kd) m_full = 0;
        @(negedge clk);
    endtask

    task automatic rd_at(input logic [15:0] a, input string tag);
        step(a, 1, 0, 16'h0, 0, 0, 8'h0, tag);
    endtask

    task automatic wr_at(input logic [15:0] a, input logic [15:0] d, input string tag);
        step(a, 0, 1, d, 0, 0, 8'h0, tag);
    endtask

    task automatic idle(input string tag);
        step(16'h0, 0, 0, 16'h0, 0, 0, 8'h0, tag);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state
        idle("R1");
        rd_at(16'hFFE2, "R1");
        rd_at(16'hFFE6, "R1");
        rd_at(16'hFFE0, "R1");
        // R2 R3 R5: write while ready, strobe next cycle
        wr_at(16'hFFE0, 16'h12A5, "R5");
        rd_at(16'hFFE2, "R5");
        rd_at(16'hFFE0, "R3");
        rd_at(16'hFFE0, "R2");
        // R5 R2: write while busy updates pins without strobe
        wr_at(16'hFFE0, 16'hFF3C, "R5");
        idle("R5");
        rd_at(16'hFFE0, "R2");
        // R6: ack in wait returns ready
        step(16'h0, 0, 0, 16'h0, 1, 0, 8'h0, "R6");
        rd_at(16'hFFE2, "R6");
        // R6: ack during strobe cycle ignored
        wr_at(16'hFFE0, 16'h0077, "R6");
        step(16'hFFE2, 1, 0, 16'h0, 1, 0, 8'h0, "R6");
        rd_at(16'hFFE2, "R6");
        step(16'hFFE2, 1, 0, 16'h0, 1, 0, 8'h0, "R6");
        rd_at(16'hFFE2, "R4");
        // R7: key strobe
        step(16'h0, 0, 0, 16'h0, 0, 1, 8'h41, "R7");
        rd_at(16'hFFE6, "R7");
        rd_at(16'hFFE4, "R7");
        rd_at(16'hFFE6, "R8");
        // R9: overrun
        step(16'h0, 0, 0, 16'h0, 0, 1, 8'h61, "R9");
        step(16'h0, 0, 0, 16'h0, 0, 1, 8'h62, "R9");
        rd_at(16'hFFE6, "R9");
        rd_at(16'hFFE6, "R9");
        // R9: new overrun during status read keeps it set
        step(16'h0, 0, 0, 16'h0, 0, 1, 8'h63, "R9");
        step(16'hFFE6, 1, 0, 16'h0, 0, 1, 8'h64, "R9");
        rd_at(16'hFFE6, "R9");
        // R8: strobe during key-code read wins, no overrun
        step(16'hFFE4, 1, 0, 16'h0, 0, 1, 8'h55, "R8");
        rd_at(16'hFFE6, "R8");
        rd_at(16'hFFE4, "R8");
        rd_at(16'hFFE6, "R8");
        // R10: writes to input-only ports ignored
        step(16'h0, 0, 0, 16'h0, 0, 1, 8'h7E, "R10");
        wr_at(16'hFFE2, 16'hFFFF, "R10");
        wr_at(16'hFFE4, 16'h00AA, "R10");
        wr_at(16'hFFE6, 16'hFFFF, "R10");
        rd_at(16'hFFE2, "R10");
        rd_at(16'hFFE4, "R10");
        rd_at(16'hFFE6, "R10");
        rd_at(16'hFFE0, "R10");
        // R11: unmapped and idle reads
        rd_at(16'hFFE8, "R11");
        rd_at(16'hFFE1, "R11");
        step(16'hFFE0, 0, 0, 16'h0, 0, 0, 8'h0, "R11");
        idle("R11");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #2000000;
        errors++;
        checks++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule